// File: doc/BRIEF.md
# Bitmap-Driven Register Index Sequencer

The block turns one three-operand operation into a run of element operations. It holds one 32-bit selection mask for each architectural register name. When an operation names a destination and two sources, the block looks up the three masks. It then walks the set bits of each mask in ascending register order, and each element receives one physical destination index and two physical source indices. The destination mask sets the run length, which is its population count. Each source list wraps around cyclically until it matches that length, and each source keeps its own scan position.

A small integer register file with an adder sits behind the sequencer as a demonstration datapath. Every element writes the sum of its two sources into its destination. All elements behave as if they execute at the same time: a source read always sees the value the register held before the operation began. The block meets this by copying the register file at the start of each operation. Software writes the masks through a configuration port and reads back the legalised mask with its population count. The element stream leaves through a valid/ready handshake, and a one-cycle done flag marks the end of each run.

Top module: `bmap_seq`

## Requirements
- R1: After reset, mask n reads back as 1<<n and its reported count is 1, so every operation defaults to a single scalar element.
- R2: Mask 0 always reads as 0x00000001, and writes to address 0 have no effect.
- R3: Writing zero to mask n (n>0) stores 1<<n. A nonzero write is stored unchanged. A mask never reads back as zero.
- R4: An operation issues exactly popcount(destination mask) elements, and the configuration port reports that popcount for the addressed mask.
- R5: Destination indices are the set bits of the destination mask in ascending order. Every scan starts from bit 0 at the beginning of each operation and wraps modulo 32.
- R6: Each source list is the ascending set bits of its own mask, repeated periodically to the destination length. Each source advances its own scan pointer independently.
- R7: Every source operand reads the register value from before the operation started, even when an earlier element of the same operation wrote that register.
- R8: Physical register 0 always reads zero, and element writes to it are discarded.
- R9: The block offers one element per cycle while elem_ready is high. While elem_valid is high and elem_ready is low, the element outputs hold steady.
- R10: done is high for exactly one cycle, in the cycle after the last element handshake, with elem_valid low. A start received while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_addr | input | 5 | Mask select for write and read |
| cfg_wdata | input | 32 | Mask write value (any value accepted) |
| cfg_rdata | output | 32 | Legalised mask at cfg_addr |
| cfg_count | output | 6 | Population count of mask at cfg_addr |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_rd | input | 5 | Destination register name |
| op_rs1 | input | 5 | First source register name |
| op_rs2 | input | 5 | Second source register name |
| busy | output | 1 | Operation in progress |
| elem_valid | output | 1 | Element indices available |
| elem_ready | input | 1 | Consumer accepts the element |
| elem_rd | output | 5 | Physical destination index |
| elem_rs1 | output | 5 | Physical first source index |
| elem_rs2 | output | 5 | Physical second source index |
| done | output | 1 | One-cycle pulse after the last element |
| rf_we | input | 1 | Direct register file write (idle only) |
| rf_addr | input | 5 | Register file address for direct access |
| rf_wdata | input | 32 | Direct register file write data |
| rf_rdata | output | 32 | Register file read data |

## Verification
The bench targets a destination mask whose lowest set bit is above zero while its sources wrap at bit 31. A scan that resumed from the previous run, or that failed to wrap, would produce wrong source indices there. It also targets an operation in which a later element reads a register that an earlier element wrote. A design without operand isolation would add the freshly written sum instead of the original value. Other cases cover a zero mask write, writes to mask 0, a destination list that includes register 0, a stall during an element, and a start pulse that arrives mid-run. A faulty design would, in turn, hang on an empty mask, corrupt the fixed entry, make register 0 nonzero, skip or repeat an element under backpressure, or launch a second run.

// File: rtl/bmap_seq.sv
module bmap_seq #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  localparam int AW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [NREG-1:0] cfg_wdata,
  output logic [NREG-1:0] cfg_rdata,
  output logic [CW-1:0]   cfg_count,
  input  logic            start,
  input  logic [AW-1:0]   op_rd,
  input  logic [AW-1:0]   op_rs1,
  input  logic [AW-1:0]   op_rs2,
  output logic            busy,
  output logic            elem_valid,
  input  logic            elem_ready,
  output logic [AW-1:0]   elem_rd,
  output logic [AW-1:0]   elem_rs1,
  output logic [AW-1:0]   elem_rs2,
  output logic            done,
  input  logic            rf_we,
  input  logic [AW-1:0]   rf_addr,
  input  logic [XLEN-1:0] rf_wdata,
  output logic [XLEN-1:0] rf_rdata
);

  function automatic logic [CW-1:0] popc(input logic [NREG-1:0] m);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CW'(m[i]);
    return c;
  endfunction

  function automatic logic [AW-1:0] scan(input logic [NREG-1:0] m, input logic [AW-1:0] p);
    logic [AW-1:0] r;
    logic [AW-1:0] idx;
    logic hit;
    r = p;
    hit = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      idx = AW'((int'(p) + i) % NREG);
      if (!hit && m[idx]) begin
        r = idx;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [AW-1:0] step(input logic [AW-1:0] i);
    return (i == AW'(NREG - 1)) ? '0 : i + AW'(1);
  endfunction

  logic [NREG-1:0] bm   [NREG];
  logic [XLEN-1:0] rf   [NREG];
  logic [XLEN-1:0] snap [NREG];

  logic [NREG-1:0] map_d, map_1, map_2;
  logic [AW-1:0]   ptr_d, ptr_1, ptr_2;
  logic [CW-1:0]   remain;
  logic            run;

  wire go  = start && !run;
  wire hsk = run && elem_ready;

  assign cfg_rdata  = bm[cfg_addr];
  assign cfg_count  = popc(bm[cfg_addr]);
  assign busy       = run;
  assign elem_valid = run;
  assign elem_rd    = scan(map_d, ptr_d);
  assign elem_rs1   = scan(map_1, ptr_1);
  assign elem_rs2   = scan(map_2, ptr_2);
  assign rf_rdata   = rf[rf_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NREG; n++) bm[n] <= NREG'(1) << n;
    end else if (cfg_we && cfg_addr != '0) begin
      bm[cfg_addr] <= (cfg_wdata == '0) ? (NREG'(1) << cfg_addr) : cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
      ptr_d  <= '0;
      ptr_1  <= '0;
      ptr_2  <= '0;
      map_d  <= '0;
      map_1  <= '0;
      map_2  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        run    <= 1'b1;
        map_d  <= bm[op_rd];
        map_1  <= bm[op_rs1];
        map_2  <= bm[op_rs2];
        remain <= popc(bm[op_rd]);
        ptr_d  <= '0;
        ptr_1  <= '0;
        ptr_2  <= '0;
      end else if (hsk) begin
        ptr_d  <= step(elem_rd);
        ptr_1  <= step(elem_rs1);
        ptr_2  <= step(elem_rs2);
        remain <= remain - CW'(1);
        if (remain == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NREG; n++) begin
        rf[n]   <= '0;
        snap[n] <= '0;
      end
    end else if (go) begin
      for (int n = 0; n < NREG; n++) snap[n] <= rf[n];
    end else if (hsk) begin
      if (elem_rd != '0) rf[elem_rd] <= snap[elem_rs1] + snap[elem_rs2];
    end else if (rf_we && !run && rf_addr != '0) begin
      rf[rf_addr] <= rf_wdata;
    end
  end

endmodule

module bmap_seq_chk #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  localparam int AW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   cfg_addr,
  input logic [NREG-1:0] cfg_rdata,
  input logic            elem_valid,
  input logic            elem_ready,
  input logic [AW-1:0]   elem_rd,
  input logic [AW-1:0]   elem_rs1,
  input logic [AW-1:0]   elem_rs2,
  input logic            done,
  input logic [NREG-1:0] map_d,
  input logic [AW-1:0]   rf_addr,
  input logic [XLEN-1:0] rf_rdata
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid && !elem_ready |=> elem_valid && $stable(elem_rd) && $stable(elem_rs1) && $stable(elem_rs2));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !elem_valid);

  assert_mask0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr == '0 |-> cfg_rdata == NREG'(1));

  assert_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata != '0);

  assert_dest_in_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> map_d[elem_rd]);

  assert_reg0_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_addr == '0 |-> rf_rdata == '0);

endmodule

bind bmap_seq bmap_seq_chk #(.NREG(NREG), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .elem_valid(elem_valid), .elem_ready(elem_ready), .elem_rd(elem_rd),
  .elem_rs1(elem_rs1), .elem_rs2(elem_rs2), .done(done), .map_d(map_d),
  .rf_addr(rf_addr), .rf_rdata(rf_rdata)
);

// File: tb/sim_bmap_seq.sv
`timescale 1ns/1ps
module sim_bmap_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_we = 0;
  logic [4:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [5:0]  cfg_count;
  logic        start = 0;
  logic [4:0]  op_rd = 0, op_rs1 = 0, op_rs2 = 0;
  logic        busy, elem_valid, done;
  logic        elem_ready = 1;
  logic [4:0]  elem_rd, elem_rs1, elem_rs2;
  logic        rf_we = 0;
  logic [4:0]  rf_addr = 0;
  logic [31:0] rf_wdata = 0;
  logic [31:0] rf_rdata;

  bmap_seq u0 (.*);

  int checks = 0, fails = 0;
  logic [31:0] mdl [32];
  logic [4:0] er [32], e1 [32], e2 [32];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_chk(input logic [4:0] a, input logic [31:0] m, input string req);
    @(negedge clk); cfg_addr = a; #1;
    chk(cfg_rdata == m, req, cfg_rdata, m);
    chk(cfg_count == 6'($countones(m)), {req, " count (R4)"}, 32'(cfg_count), 32'($countones(m)));
  endtask

  task automatic rf_chk_all(input string req);
    for (int n = 0; n < 32; n++) begin
      @(negedge clk); rf_addr = 5'(n); #1;
      chk(rf_rdata == mdl[n], req, rf_rdata, mdl[n]);
    end
  endtask

  task automatic run_op(input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
                        input int n, input bit bp, input bit dstart, input string req);
    logic [31:0] nv [32];
    for (int k = 0; k < 32; k++) nv[k] = mdl[k];
    for (int k = 0; k < n; k++) if (er[k] != 0) nv[er[k]] = mdl[e1[k]] + mdl[e2[k]];
    for (int k = 0; k < 32; k++) mdl[k] = nv[k];
    @(negedge clk); start = 1; op_rd = d; op_rs1 = s1; op_rs2 = s2;
    @(negedge clk); start = 0;
    for (int i = 0; i < n; i++) begin
      chk(elem_valid == 1, {req, " valid (R4)"}, 32'(elem_valid), 1);
      if (bp && i == 0) begin
        elem_ready = 0;
        for (int w = 0; w < 3; w++) begin
          @(negedge clk);
          chk(elem_valid && elem_rd == er[0] && elem_rs1 == e1[0], "R9 stall hold",
              {elem_rs1, elem_rd}, {e1[0], er[0]});
        end
        elem_ready = 1;
      end
      chk(elem_rd == er[i], {req, " rd (R5)"}, 32'(elem_rd), 32'(er[i]));
      chk(elem_rs1 == e1[i], {req, " rs1 (R6)"}, 32'(elem_rs1), 32'(e1[i]));
      chk(elem_rs2 == e2[i], {req, " rs2 (R6)"}, 32'(elem_rs2), 32'(e2[i]));
      chk(done == 0, "R10 no early done", 32'(done), 0);
      if (dstart && i == 1) begin start = 1; op_rd = 2; op_rs1 = 2; op_rs2 = 2; end
      @(negedge clk); start = 0;
    end
    chk(done == 1 && elem_valid == 0, "R10 done after last", {done, elem_valid}, 2);
    @(negedge clk);
    chk(done == 0 && elem_valid == 0 && busy == 0, "R10 done single pulse / no restart",
        {done, elem_valid, busy}, 0);
  endtask

  task automatic t_reset;
    for (int n = 0; n < 32; n += 5) cfg_chk(5'(n), 32'(1) << n, "R1 reset mask");
    cfg_chk(31, 32'h8000_0000, "R1 reset mask 31");
    for (int n = 0; n < 32; n++) mdl[n] = 0;
    rf_chk_all("R8 rf reset");
  endtask

  task automatic t_legal;
    cfg_wr(0, 32'hFFFF_FFFF);
    cfg_chk(0, 1, "R2 mask0 fixed");
    cfg_wr(9, 0);
    cfg_chk(9, 32'h200, "R3 zero legalised");
    cfg_wr(13, 32'h30);
    cfg_chk(13, 32'h30, "R3 nonzero kept");
  endtask

  task automatic t_load;
    for (int n = 0; n < 32; n++) begin
      @(negedge clk); rf_we = 1; rf_addr = 5'(n); rf_wdata = 32'(100 * n + 7);
      mdl[n] = (n == 0) ? 0 : 32'(100 * n + 7);
    end
    @(negedge clk); rf_we = 0;
    rf_chk_all("R8 rf load, reg0 stays zero");
  endtask

  task automatic t_scalar;
    er[0] = 3; e1[0] = 4; e2[0] = 5;
    run_op(3, 4, 5, 1, 0, 0, "R1 scalar");
    rf_chk_all("R7 scalar result");
  endtask

  task automatic t_vector;
    cfg_wr(5, 32'h1F);
    cfg_wr(6, 32'h0B);
    cfg_wr(7, 32'h02);
    cfg_chk(5, 32'h1F, "R4 dest count");
    er = '{default: 0}; e1 = '{default: 0}; e2 = '{default: 0};
    er[0]=0; er[1]=1; er[2]=2; er[3]=3; er[4]=4;
    e1[0]=0; e1[1]=1; e1[2]=3; e1[3]=0; e1[4]=1;
    for (int k = 0; k < 5; k++) e2[k] = 1;
    run_op(5, 6, 7, 5, 0, 1, "R6 vector");
    rf_chk_all("R7 parallel reads / R8 reg0 write dropped");
  endtask

  task automatic t_wrap;
    cfg_wr(10, 32'hF000_0004);
    cfg_wr(11, 32'h8000_0002);
    er[0]=2; er[1]=28; er[2]=29; er[3]=30; er[4]=31;
    e1[0]=1; e1[1]=31; e1[2]=1; e1[3]=31; e1[4]=1;
    for (int k = 0; k < 5; k++) e2[k] = 12;
    run_op(10, 11, 12, 5, 1, 0, "R5 wrap");
    rf_chk_all("R7 wrap results");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_legal;
    t_load;
    t_scalar;
    t_vector;
    t_wrap;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule